// File: doc/BRIEF.md
# Hash Engine Register Front-End

This block is the register-mapped control shell that sits between a 32-bit register bus and a combined SHA-1/MD5 compression engine. Software or a DMA channel opens a chunk by writing a control word. The word holds the chunk length in bytes, the algorithm, a flag that starts from the standard initial chaining values, and a flag that asks for final padding. The caller then feeds the chunk's data words. The front-end gathers the words and launches the engine. When the engine finishes, the front-end stores the new chaining state, adds the chunk length to a running byte count and raises a completion flag with an optional interrupt.

The chaining state and the running byte count are both readable and writable between chunks. A hash can therefore be suspended, another message can be processed, and the first hash can later be resumed. A soft reset clears the block and then reports completion. The compression rounds are a stub with a fixed latency and a simple mixing rule, so the register behaviour can be checked exactly.

Flow control on the data path works by back-pressure. Data words are accepted only while input-ready is high. Input-ready rises when a chunk is opened and falls in the cycle after the last required word is written. While DMA is enabled, the DMA request line follows input-ready, and every DMA beat targets the first data address.

Top module: `hash_regfront`

## Requirements
- R1: Byte-addressed map with word index = address[7:2]: digest words 0..4 at 0x00..0x10, running count at 0x14, control at 0x18, data words 0..15 at 0x1C..0x58 (these read as zero), revision at 0x5C, config at 0x60, status at 0x64. Misaligned addresses and any other offset read zero, and writes to them change nothing.
- R2: Control word fields are: bit 0 output-ready, bit 1 input-ready (read only), bit 2 algorithm (1 = SHA-1, 0 = MD5), bit 3 start-from-constants, bit 4 close, bits 31:5 length in bytes. A control write with nonzero length opens a chunk that needs min(ceil(length/4), 16) data words, and input-ready then reads 1. Input-ready drops at the clock edge that takes the last word. Data writes made while no chunk is open are ignored.
- R3: Opening a chunk with start-from-constants loads the digest with 67452301, EFCDAB89, 98BADCFE, 10325476, and C3D2E1F0 for SHA-1 or 0 for MD5 as word 4, and zeroes the count. Without the flag, the chunk continues from whatever digest and count values were written back.
- R4: The engine stub sets each stored digest word k to old_k + F + k (mod 2^32), where F is the XOR of the chunk's required data words.
- R5: For a chunk opened with close set, each new word from R4 is further XORed with (count + length), where count is the value before the chunk.
- R6: On completion the count increases by the chunk length and output-ready is set. The irq output equals output-ready AND the interrupt-enable bit of the config word (bit 2).
- R7: Writing a control word with bit 0 = 1 clears output-ready and drops irq. A control write with length 0 opens no chunk.
- R8: In SHA-1 mode (control bit 2 = 1), digest words are byte-reversed on both read and write. In MD5 mode they pass unchanged.
- R9: With DMA enable (config bit 3) set, dma_req is high exactly while a chunk is open. Writes to 0x1C then fill data words in arrival order.
- R10: A control write with close set and nonzero length is rejected when (count after any constant load + length) < 9. The chunk is not opened, and status bit 1 reads 1 until the next accepted control write.
- R11: Writing 1 to config bit 1 starts a soft reset that clears all state. During it, status bit 0 reads 0 and config bit 1 reads 1. After SRST_CYCLES cycles, status bit 0 returns to 1.
- R12: The revision word reads {24'b0, REV_MAJOR[3:0], REV_MINOR[3:0]}, which is 0x21 by default.
- R13: idle_ok = config bit 0 (auto-idle) AND control length field = 0 AND no chunk is open, launching, in progress or completing.
- R14: While a chunk is open or in progress, writes to the digest, the count and the control fields are ignored. The only exception is the output-ready clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Completion interrupt |
| dma_req | output | 1 | Request for more data words by DMA |
| idle_ok | output | 1 | Block may be clock-gated |

## Verification
The bench resumes hashes from written-back SHA-1 state. A design that forgot the byte reversal on the write path, or reloaded the constants, would return a wrong digest. It sends lengths above 64 bytes and lengths that are not whole words, which catches a faulty word-count rounding or clamp: the engine would fire early or never. It writes junk to the digest, count and control registers while a chunk is in flight, which exposes a missing lock through a corrupted result. It makes a stray DMA-address write before a chunk is opened, which catches a pointer that counts when idle. It probes the 8-byte boundary of the short-message rule, so an off-by-one would either reject a valid 9-byte message or accept an 8-byte one.

// File: rtl/hrf_pkg.sv
`timescale 1ns/1ps
package hrf_pkg;
  typedef logic [31:0] word_t;

  localparam int LEN_W         = 27;
  localparam int DIG_WORDS     = 5;
  localparam int MIN_MSG_BYTES = 9;

  // fixed word indices at the low end of the map; later ones derive from NWORDS
  localparam logic [5:0] IDX_COUNT = 6'd5;
  localparam logic [5:0] IDX_CTRL  = 6'd6;
  localparam logic [5:0] IDX_DATA0 = 6'd7;

  function automatic word_t swap_bytes(word_t w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic word_t start_word(int unsigned k, logic sha1);
    case (k)
      0: return 32'h6745_2301;
      1: return 32'hEFCD_AB89;
      2: return 32'h98BA_DCFE;
      3: return 32'h1032_5476;
      default: return sha1 ? 32'hC3D2_E1F0 : 32'h0;
    endcase
  endfunction
endpackage

// File: rtl/hrf_softreset.sv
`timescale 1ns/1ps
module hrf_softreset #(
  parameter int CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic busy,
  output logic done_flag
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;

  assign busy = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      done_flag <= 1'b1;
    end else if (trig && !busy) begin
      cnt       <= CW'(CYCLES);
      done_flag <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - CW'(1);
      if (cnt == CW'(1)) done_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/hrf_inbuf.sv
`timescale 1ns/1ps
module hrf_inbuf
  import hrf_pkg::*;
#(
  parameter int NWORDS = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         arm,
  input  logic [$clog2(NWORDS+1)-1:0]  arm_words,
  input  logic                         wr,
  input  logic [$clog2(NWORDS)-1:0]    wr_slot,
  input  logic                         dma_mode,
  input  word_t                        wdata,
  output logic                         in_ready,
  output logic                         go,
  output logic                         dma_req,
  output word_t                        fold
);
  localparam int IW = $clog2(NWORDS);
  localparam int CW = $clog2(NWORDS + 1);

  word_t         mem [NWORDS];
  logic          armed;
  logic [CW-1:0] need;
  logic [CW-1:0] got;
  logic [IW-1:0] slot;
  logic          last_beat;

  // DMA beats all hit one address, so they land in arrival order
  assign slot      = dma_mode ? got[IW-1:0] : wr_slot;
  assign last_beat = (got + CW'(1)) == need;
  assign in_ready  = armed;
  assign dma_req   = armed && dma_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      need  <= '0;
      got   <= '0;
      go    <= 1'b0;
      for (int i = 0; i < NWORDS; i++) mem[i] <= '0;
    end else if (clr) begin
      armed <= 1'b0;
      need  <= '0;
      got   <= '0;
      go    <= 1'b0;
      for (int i = 0; i < NWORDS; i++) mem[i] <= '0;
    end else begin
      go <= 1'b0;
      if (arm) begin
        armed <= 1'b1;
        need  <= arm_words;
        got   <= '0;
      end else if (wr && armed) begin
        mem[slot] <= wdata;
        got       <= got + CW'(1);
        if (last_beat) begin
          armed <= 1'b0;
          go    <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    fold = '0;
    for (int i = 0; i < NWORDS; i++)
      if (CW'(i) < need) fold = fold ^ mem[i];
  end
endmodule

// File: rtl/hrf_engine_stub.sv
`timescale 1ns/1ps
module hrf_engine_stub
  import hrf_pkg::*;
#(
  parameter int LAT = 6,
  parameter int DW  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             go,
  input  word_t            fold,
  input  word_t            total,
  input  logic             close,
  input  logic [DW*32-1:0] st_in,
  output logic             busy,
  output logic             done,
  output logic [DW*32-1:0] st_out
);
  localparam int LW = $clog2(LAT + 1);

  logic [LW-1:0]    tmr;
  word_t            fold_q;
  word_t            total_q;
  logic             close_q;
  logic [DW*32-1:0] st_q;
  logic [DW*32-1:0] nxt;

  for (genvar k = 0; k < DW; k++) begin : g_mix
    word_t t;
    assign t = st_q[k*32 +: 32] + fold_q + word_t'(k);
    assign nxt[k*32 +: 32] = close_q ? (t ^ total_q) : t;
  end

  assign busy = (tmr != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr     <= '0;
      fold_q  <= '0;
      total_q <= '0;
      close_q <= 1'b0;
      st_q    <= '0;
      st_out  <= '0;
      done    <= 1'b0;
    end else if (clr) begin
      tmr     <= '0;
      fold_q  <= '0;
      total_q <= '0;
      close_q <= 1'b0;
      st_q    <= '0;
      st_out  <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        fold_q  <= fold;
        total_q <= total;
        close_q <= close;
        st_q    <= st_in;
        tmr     <= LW'(LAT);
      end else if (busy) begin
        tmr <= tmr - LW'(1);
        if (tmr == LW'(1)) begin
          done   <= 1'b1;
          st_out <= nxt;
        end
      end
    end
  end
endmodule

// File: rtl/hash_regfront.sv
`timescale 1ns/1ps
module hash_regfront
  import hrf_pkg::*;
#(
  parameter int         NWORDS      = 16,
  parameter int         SRST_CYCLES = 4,
  parameter int         ENG_LAT     = 6,
  parameter logic [3:0] REV_MAJOR   = 4'd2,
  parameter logic [3:0] REV_MINOR   = 4'd1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        dma_req,
  output logic        idle_ok
);
  localparam int         IW        = $clog2(NWORDS);
  localparam int         CW        = $clog2(NWORDS + 1);
  localparam int         BLK_BYTES = 4 * NWORDS;
  localparam logic [5:0] IDX_DLAST = 6'(int'(IDX_DATA0) + NWORDS - 1);
  localparam logic [5:0] IDX_REV   = 6'(int'(IDX_DATA0) + NWORDS);
  localparam logic [5:0] IDX_MASK  = 6'(int'(IDX_DATA0) + NWORDS + 1);
  localparam logic [5:0] IDX_STAT  = 6'(int'(IDX_DATA0) + NWORDS + 2);

  // architectural state
  word_t             st [DIG_WORDS];
  word_t             cnt;
  logic [LEN_W-1:0]  len_q;
  logic              sha1_q, init_q, close_q;
  logic              out_ready, short_q;
  logic              auto_idle, irq_en, dma_en;

  // links between sub-blocks
  logic              srst_busy, reset_done;
  logic              in_ready, go, eng_busy, eng_done;
  word_t             fold;
  logic [DIG_WORDS*32-1:0] st_flat, res_flat;

  // bus decode
  logic [5:0] idx;
  logic       aligned, wr_ok;
  logic       wr_dig, wr_cnt, wr_ctrl, wr_data, wr_mask;
  logic       lock;

  assign idx     = bus_addr[7:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr_ok   = bus_wr && aligned && !srst_busy;
  assign wr_dig  = wr_ok && (idx < 6'(DIG_WORDS));
  assign wr_cnt  = wr_ok && (idx == IDX_COUNT);
  assign wr_ctrl = wr_ok && (idx == IDX_CTRL);
  assign wr_data = wr_ok && (idx >= IDX_DATA0) && (idx <= IDX_DLAST);
  assign wr_mask = wr_ok && (idx == IDX_MASK);

  // a chunk is anywhere between opened and retired
  assign lock = in_ready || go || eng_busy || eng_done;

  // fields of an incoming control word
  logic [LEN_W-1:0] w_len;
  logic             w_close, w_init, w_sha1;
  word_t            base_cnt, tot_chk;
  logic             too_short, arm;
  logic [LEN_W-1:0] len_rnd;
  logic [CW-1:0]    arm_words;

  assign w_len    = bus_wdata[31:5];
  assign w_close  = bus_wdata[4];
  assign w_init   = bus_wdata[3];
  assign w_sha1   = bus_wdata[2];
  assign base_cnt = w_init ? '0 : cnt;
  assign tot_chk  = base_cnt + {{(32-LEN_W){1'b0}}, w_len};
  assign too_short = w_close && (w_len != '0) && (tot_chk < word_t'(MIN_MSG_BYTES));
  assign arm      = wr_ctrl && !lock && (w_len != '0) && !too_short;
  assign len_rnd  = w_len + LEN_W'(3);

  always_comb begin
    if (w_len >= LEN_W'(BLK_BYTES)) arm_words = CW'(NWORDS);
    else                            arm_words = CW'(len_rnd >> 2);
  end

  for (genvar k = 0; k < DIG_WORDS; k++) begin : g_flat
    assign st_flat[k*32 +: 32] = st[k];
  end

  hrf_softreset #(.CYCLES(SRST_CYCLES)) u_srst (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig      (wr_mask && bus_wdata[1]),
    .busy      (srst_busy),
    .done_flag (reset_done)
  );

  hrf_inbuf #(.NWORDS(NWORDS)) u_inbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (srst_busy),
    .arm       (arm),
    .arm_words (arm_words),
    .wr        (wr_data),
    .wr_slot   (IW'(idx - IDX_DATA0)),
    .dma_mode  (dma_en),
    .wdata     (bus_wdata),
    .in_ready  (in_ready),
    .go        (go),
    .dma_req   (dma_req),
    .fold      (fold)
  );

  hrf_engine_stub #(.LAT(ENG_LAT), .DW(DIG_WORDS)) u_eng (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (srst_busy),
    .go     (go),
    .fold   (fold),
    .total  (cnt + {{(32-LEN_W){1'b0}}, len_q}),
    .close  (close_q),
    .st_in  (st_flat),
    .busy   (eng_busy),
    .done   (eng_done),
    .st_out (res_flat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DIG_WORDS; k++) st[k] <= '0;
      cnt       <= '0;
      len_q     <= '0;
      sha1_q    <= 1'b0;
      init_q    <= 1'b0;
      close_q   <= 1'b0;
      out_ready <= 1'b0;
      short_q   <= 1'b0;
      auto_idle <= 1'b0;
      irq_en    <= 1'b0;
      dma_en    <= 1'b0;
    end else if (srst_busy) begin
      for (int k = 0; k < DIG_WORDS; k++) st[k] <= '0;
      cnt       <= '0;
      len_q     <= '0;
      sha1_q    <= 1'b0;
      init_q    <= 1'b0;
      close_q   <= 1'b0;
      out_ready <= 1'b0;
      short_q   <= 1'b0;
      auto_idle <= 1'b0;
      irq_en    <= 1'b0;
      dma_en    <= 1'b0;
    end else begin
      // completion wins over a same-cycle clear
      if (eng_done) begin
        for (int k = 0; k < DIG_WORDS; k++) st[k] <= res_flat[k*32 +: 32];
        cnt       <= cnt + {{(32-LEN_W){1'b0}}, len_q};
        out_ready <= 1'b1;
      end else if (wr_ctrl && bus_wdata[0]) begin
        out_ready <= 1'b0;
      end

      if (!lock) begin
        for (int k = 0; k < DIG_WORDS; k++)
          if (wr_dig && idx == 6'(k))
            st[k] <= sha1_q ? swap_bytes(bus_wdata) : bus_wdata;
        if (wr_cnt) cnt <= bus_wdata;
        if (wr_ctrl) begin
          len_q   <= w_len;
          close_q <= w_close;
          init_q  <= w_init;
          sha1_q  <= w_sha1;
          short_q <= too_short;
          if (arm && w_init) begin
            for (int k = 0; k < DIG_WORDS; k++) st[k] <= start_word(k, w_sha1);
            cnt <= '0;
          end
        end
      end

      if (wr_mask) begin
        auto_idle <= bus_wdata[0];
        irq_en    <= bus_wdata[2];
        dma_en    <= bus_wdata[3];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      for (int k = 0; k < DIG_WORDS; k++)
        if (idx == 6'(k)) bus_rdata = sha1_q ? swap_bytes(st[k]) : st[k];
      if (idx == IDX_COUNT) bus_rdata = cnt;
      if (idx == IDX_CTRL)  bus_rdata = {len_q, close_q, init_q, sha1_q, in_ready, out_ready};
      if (idx == IDX_REV)   bus_rdata = {24'b0, REV_MAJOR, REV_MINOR};
      if (idx == IDX_MASK)  bus_rdata = {28'b0, dma_en, irq_en, srst_busy, auto_idle};
      if (idx == IDX_STAT)  bus_rdata = {30'b0, short_q, reset_done};
    end
  end

  assign irq     = out_ready && irq_en;
  assign idle_ok = auto_idle && (len_q == '0) && !lock;
endmodule

// File: rtl/hrf_checker.sv
`timescale 1ns/1ps
module hrf_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [7:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        irq,
  input logic        dma_req,
  input logic        in_ready,
  input logic        eng_busy,
  input logic        eng_done,
  input logic        out_ready,
  input logic        irq_en,
  input logic        dma_en,
  input logic        srst_busy,
  input logic        reset_done
);
  // R1
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[1:0] != 2'b00 || bus_addr > 8'h64) |-> bus_rdata == 32'h0);

  // R2
  ready_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && eng_busy));

  // R6
  done_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && !srst_busy) |=> out_ready);

  // R6
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_en);

  // R7
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h18 && bus_wdata[0] && !eng_done && !srst_busy)
      |=> (!out_ready && !irq));

  // R9
  dma_req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> (dma_en && in_ready));

  // R11
  srst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h60 && bus_wdata[1] && !srst_busy)
      |=> (srst_busy && !reset_done));
endmodule

bind hash_regfront hrf_checker chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .irq        (irq),
  .dma_req    (dma_req),
  .in_ready   (in_ready),
  .eng_busy   (eng_busy),
  .eng_done   (eng_done),
  .out_ready  (out_ready),
  .irq_en     (irq_en),
  .dma_en     (dma_en),
  .srst_busy  (srst_busy),
  .reset_done (reset_done)
);

// File: tb/hash_regfront_tb.sv
`timescale 1ns/1ps
module hash_regfront_tb_top;
  localparam logic [7:0] A_CNT = 8'h14, A_CTRL = 8'h18, A_DIN = 8'h1C;
  localparam logic [7:0] A_REV = 8'h5C, A_MASK = 8'h60, A_STAT = 8'h64;
  localparam int SRST = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, dma_req, idle_ok;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] m_st [5];
  logic [31:0] m_cnt = '0;
  logic        m_irq_en = 1'b0;
  logic        m_auto = 1'b0;

  always #2.5 clk = ~clk;

  hash_regfront #(.SRST_CYCLES(SRST)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .dma_req(dma_req), .idle_ok(idle_ok)
  );

  function automatic logic [31:0] swp(logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic [31:0] iv(int k, bit sha1);
    logic [31:0] t [5] = '{32'h67452301, 32'hEFCDAB89, 32'h98BADCFE, 32'h10325476, 32'hC3D2E1F0};
    if (k == 4 && !sha1) return 32'h0;
    return t[k];
  endfunction

  function automatic int nwords(int len);
    return (len >= 64) ? 16 : (len + 3) / 4;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic set_mask(bit dma, bit ien, bit aut);
    wr(A_MASK, {28'b0, dma, ien, 1'b0, aut});
    m_irq_en = ien; m_auto = aut;
  endtask

  task automatic check_digest(string tag, bit sha1);
    logic [31:0] d;
    for (int k = 0; k < 5; k++) begin
      rd(8'(4 * k), d);
      check(tag, d, sha1 ? swp(m_st[k]) : m_st[k]);
    end
    rd(A_CNT, d);
    check("R6 count advanced by length", d, m_cnt);
  endtask

  task automatic run_chunk(bit sha1, bit init, bit close, int len, bit use_dma, bit poke);
    logic [31:0] d, fold, t;
    int n;
    n = nwords(len);
    fold = '0;
    if (use_dma) wr(A_DIN, 32'hDEAD_0001);  // stray beat while idle: R2 says ignored
    if (init) begin
      for (int k = 0; k < 5; k++) m_st[k] = iv(k, sha1);
      m_cnt = '0;
    end
    wr(A_CTRL, {len[26:0], close, init, sha1, 2'b00});
    rd(A_CTRL, d);
    check("R2 input-ready after open", {31'b0, d[1]}, 32'd1);
    check("R13 idle_ok low while open", {31'b0, idle_ok}, 32'd0);
    if (poke) begin  // R14: all of these must be dropped
      wr(8'h00, 32'hBAD0_BAD0);
      wr(A_CNT, 32'h0BAD_0000);
      wr(A_CTRL, {27'd4, 1'b0, 1'b1, ~sha1, 2'b00});
      rd(A_CTRL, d);
      check("R14 control fields unchanged while open", d[31:2], {len[26:0], close, init, sha1});
    end
    for (int i = 0; i < n; i++) begin
      d = $urandom;
      fold ^= d;
      if (use_dma) begin
        check("R9 dma_req while words pending", {31'b0, dma_req}, 32'd1);
        wr(A_DIN, d);
      end else begin
        wr(8'(28 + 4 * (n - 1 - i)), d);
      end
    end
    rd(A_CTRL, d);
    check("R2 input-ready drops after last word", {31'b0, d[1]}, 32'd0);
    check("R9 dma_req low after last word", {31'b0, dma_req}, 32'd0);
    for (int k = 0; k < 5; k++) begin
      t = m_st[k] + fold + 32'(k);
      if (close) t = t ^ (m_cnt + 32'(len));
      m_st[k] = t;
    end
    m_cnt = m_cnt + 32'(len);
    for (int i = 0; i < 60; i++) begin
      rd(A_CTRL, d);
      if (d[0]) break;
    end
    check("R6 output-ready set on completion", {31'b0, d[0]}, 32'd1);
    check("R6 irq follows enable", {31'b0, irq}, {31'b0, m_irq_en});
    check("R13 idle_ok low with length set", {31'b0, idle_ok}, 32'd0);
    check_digest(close ? "R5 closed digest (R4 R8)" : "R4 digest update (R8)", sha1);
    wr(A_CTRL, {29'b0, sha1, 2'b01});
    rd(A_CTRL, d);
    check("R7 output-ready cleared", {31'b0, d[0]}, 32'd0);
    check("R7 irq dropped", {31'b0, irq}, 32'd0);
    check("R13 idle_ok after length cleared", {31'b0, idle_ok}, {31'b0, m_auto});
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    logic [31:0] d;
    logic [31:0] v [5];
    void'($urandom(32'd7321));
    for (int k = 0; k < 5; k++) m_st[k] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // reset state and map
    rd(A_STAT, d);  check("R11 reset-done after power-on", d, 32'h1);
    rd(A_CTRL, d);  check("R2 control clear after reset", d, 32'h0);
    rd(A_MASK, d);  check("R1 config clear after reset", d, 32'h0);
    rd(A_REV, d);   check("R12 revision word", d, 32'h21);
    rd(8'h70, d);   check("R1 unmapped reads zero", d, 32'h0);
    rd(8'h19, d);   check("R1 misaligned reads zero", d, 32'h0);
    check("R6 irq low after reset", {31'b0, irq}, 32'd0);
    wr(8'h68, 32'hFFFF_FFFF);
    rd(8'h68, d);   check("R1 unmapped write ignored", d, 32'h0);
    rd(A_MASK, d);  check("R1 unmapped write leaves config", d, 32'h0);

    // directed chunks
    set_mask(1'b0, 1'b1, 1'b1);
    check("R13 idle_ok when auto-idle set", {31'b0, idle_ok}, 32'd1);
    run_chunk(1'b1, 1'b1, 1'b1, 20, 1'b0, 1'b0);
    rd(8'h20, d);   check("R1 data window reads zero", d, 32'h0);
    run_chunk(1'b0, 1'b1, 1'b0, 100, 1'b0, 1'b0);  // R2 clamp to 16 words
    run_chunk(1'b0, 1'b0, 1'b1, 13, 1'b0, 1'b0);
    set_mask(1'b1, 1'b0, 1'b0);
    run_chunk(1'b1, 1'b1, 1'b0, 64, 1'b1, 1'b0);
    run_chunk(1'b1, 1'b0, 1'b1, 37, 1'b1, 1'b1);   // R14 poke during DMA chunk

    // R3 / R8: resume from written-back SHA-1 state
    wr(A_CTRL, {27'd0, 1'b0, 1'b0, 1'b1, 2'b00});
    for (int k = 0; k < 5; k++) begin
      v[k] = $urandom;
      wr(8'(4 * k), v[k]);
      m_st[k] = swp(v[k]);
    end
    wr(A_CNT, 32'd640);
    m_cnt = 32'd640;
    wr(A_CTRL, {27'd0, 1'b0, 1'b0, 1'b0, 2'b00});
    rd(8'h00, d);   check("R8 MD5 view shows reversed bytes", d, swp(v[0]));
    set_mask(1'b0, 1'b1, 1'b0);
    run_chunk(1'b1, 1'b0, 1'b1, 30, 1'b0, 1'b1);   // R3 resume, R14 poke

    // R10 short-message rule at the 8/9 byte boundary
    wr(A_CTRL, {27'd8, 1'b1, 1'b1, 1'b0, 2'b00});
    rd(A_STAT, d);  check("R10 fresh 8-byte message rejected", d, 32'h3);
    rd(A_CTRL, d);  check("R10 rejected chunk not opened", {31'b0, d[1]}, 32'd0);
    wr(A_CNT, 32'd3);
    wr(A_CTRL, {27'd5, 1'b1, 1'b0, 1'b0, 2'b00});
    rd(A_STAT, d);  check("R10 resumed 3+5 rejected", d, 32'h3);
    m_cnt = 32'd3;
    run_chunk(1'b0, 1'b0, 1'b1, 6, 1'b0, 1'b0);    // 3+6 = 9 accepted
    rd(A_STAT, d);  check("R10 flag cleared by accepted write", d, 32'h1);
    run_chunk(1'b0, 1'b1, 1'b1, 9, 1'b0, 1'b0);

    // constrained random messages
    for (int m = 0; m < 12; m++) begin
      bit sha1, dma, ien;
      int nch, len;
      sha1 = 1'($urandom);
      dma  = 1'($urandom);
      ien  = 1'($urandom);
      nch  = 1 + int'($urandom % 3);
      set_mask(dma, ien, 1'($urandom));
      for (int c = 0; c < nch; c++) begin
        len = 9 + int'($urandom % 92);
        run_chunk(sha1, c == 0, c == nch - 1, len, dma, 1'($urandom % 4 == 0));
      end
    end

    // R11 soft reset
    wr(A_MASK, 32'h6);
    rd(A_STAT, d);  check("R11 reset-done low during soft reset", d, 32'h0);
    rd(A_MASK, d);  check("R11 soft-reset bit reads set", {31'b0, d[1]}, 32'd1);
    repeat (SRST + 2) @(negedge clk);
    rd(A_STAT, d);  check("R11 reset-done back", d, 32'h1);
    rd(A_MASK, d);  check("R11 config cleared", d, 32'h0);
    rd(8'h00, d);   check("R11 digest cleared", d, 32'h0);
    rd(A_CNT, d);   check("R11 count cleared", d, 32'h0);
    rd(A_CTRL, d);  check("R11 control cleared", d, 32'h0);

    finish_up();
  end
endmodule